// File: doc/BRIEF.md
# Scaled-Displacement Load/Store Address Unit

This unit sits between instruction decode and a data memory port. It takes one move operation at a time: a 4-bit operation selector, a 12-bit displacement, a 32-bit base register value, a floating-point wide-mode flag and up to 64 bits of store data. From these it forms the effective address, the access width and the direction. It then runs the transfer on a simple memory port that has a request/ready phase and a response-valid phase. For loads, it turns the returned word into a register-ready result.

The displacement is treated as unsigned and scaled by the access width before it is added to the base. Narrow loads come in signed and unsigned forms. Floating-point moves use 4-byte scaling and a single 32-bit beat, or, in wide mode, 8-byte scaling and two 32-bit beats. The unit holds one operation at a time. It stays busy until the last response arrives and then pulses `done` with the result. A selector that names no operation produces a one-cycle exception pulse and no memory traffic.

Top module: `ldst_disp_unit`

## Requirements
- R1: Direction follows the selector. Codes 0x0 to 0x3 are stores, which drive `mem_we`=1 and put `st_data[31:0]` on `mem_wdata` for a single beat. Codes 0x4 to 0x9 are loads and drive `mem_we`=0.
- R2: For byte (0x0, 0x4, 0x8), halfword (0x1, 0x5, 0x9) and word (0x2, 0x6) operations, the address is the base plus the displacement times 1, 2 or 4, modulo 2^32.
- R3: Floating-point moves (0x3, 0x7) scale the displacement by 4 when `fp_wide`=0 and by 8 when `fp_wide`=1.
- R4: A wide floating-point move makes two 32-bit beats: the first at the computed address and the second at that address plus 4. A store sends `st_data[63:32]` in the first beat and `st_data[31:0]` in the second. A load places the first returned word in `result[63:32]` and the second in `result[31:0]`.
- R5: Signed byte and halfword loads (0x4, 0x5) sign-extend bit 7 or bit 15 of `mem_rdata` to 32 bits in `result[31:0]`.
- R6: Unsigned byte and halfword loads (0x8, 0x9) zero-extend to 32 bits.
- R7: `mem_size` is 0 for byte, 1 for halfword and 2 for every 32-bit beat. Word and narrow floating loads return `mem_rdata` unchanged. For every single-beat load, `result[63:32]` is zero.
- R8: A selector from 0xA to 0xF raises `exc` for exactly the cycle after acceptance. It issues no memory request and does not make the unit busy.
- R9: `busy` rises in the cycle after a legal operation is accepted and falls when `done` pulses. `op_valid` is ignored while `busy` is high, and an operation presented in the `done` cycle is accepted.
- R10: Once `mem_req` is raised, it stays high with a stable address, direction and size until `mem_ready` is seen.
- R11: The displacement is zero-extended. A displacement of 0xFFF adds 4095 times the scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation selector |
| op_disp | input | 12 | Unsigned displacement |
| op_base | input | 32 | Base register value |
| fp_wide | input | 1 | Floating-point 8-byte mode |
| st_data | input | 64 | Store data (high word used first in wide mode) |
| busy | output | 1 | Operation in flight |
| exc | output | 1 | Undefined selector pulse |
| mem_req | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Beat address |
| mem_we | output | 1 | Beat is a write |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | 32 | Beat write data |
| mem_rvalid | input | 1 | Beat response valid |
| mem_rdata | input | 32 | Beat read data, right-aligned |
| done | output | 1 | Operation complete pulse |
| result | output | 64 | Formatted load result |

## Verification
Two things can land in the same cycle: the completion of one operation (its `done` pulse) and the presentation of the next operation. The bench provokes this by driving a new operation in exactly the cycle it sees `done`. It then judges that the second operation was accepted and that its addresses and result are correct. Separately, an undefined selector is held on `op_valid` for the whole time a legal transfer is in flight. That transfer must finish unchanged, with no `exc` pulse, and this shows the unit ignores offers while busy. Memory handshake delays are random, and the expected addresses, beat orders and extensions are computed by bench functions from the selector encoding.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef struct packed {
        logic       legal;
        logic       store;
        logic       zext;
        logic       two_beat;
        logic [1:0] shift;
        size_e      size;
    } dec_t;

    function automatic dec_t decode_op(input logic [3:0] sel, input logic wide);
        dec_t d;
        d = '{legal: 1'b1, store: 1'b0, zext: 1'b0, two_beat: 1'b0,
              shift: 2'd2, size: SZ_WORD};
        case (sel)
            4'h0: begin d.store = 1'b1; d.shift = 2'd0; d.size = SZ_BYTE; end
            4'h1: begin d.store = 1'b1; d.shift = 2'd1; d.size = SZ_HALF; end
            4'h2: d.store = 1'b1;
            4'h3: begin d.store = 1'b1; d.two_beat = wide; d.shift = wide ? 2'd3 : 2'd2; end
            4'h4: begin d.shift = 2'd0; d.size = SZ_BYTE; end
            4'h5: begin d.shift = 2'd1; d.size = SZ_HALF; end
            4'h6: ;
            4'h7: begin d.two_beat = wide; d.shift = wide ? 2'd3 : 2'd2; end
            4'h8: begin d.shift = 2'd0; d.size = SZ_BYTE; d.zext = 1'b1; end
            4'h9: begin d.shift = 2'd1; d.size = SZ_HALF; d.zext = 1'b1; end
            default: d.legal = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [3:0] sel,
    input  logic       wide,
    output dec_t       dec
);
    always_comb dec = decode_op(sel, wide);
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 12
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        shift,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - DISP_W;
    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{PAD_W{1'b0}}, disp};
        addr     = base + (disp_ext << shift);
    end
endmodule

// File: rtl/ldst_extend.sv
module ldst_extend
    import ldst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  size_e             size,
    input  logic              zext,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] ext
);
    localparam int B_W = 8;
    localparam int H_W = 16;

    always_comb begin
        case (size)
            SZ_BYTE: ext = {{(DATA_W-B_W){~zext & raw[B_W-1]}}, raw[B_W-1:0]};
            SZ_HALF: ext = {{(DATA_W-H_W){~zext & raw[H_W-1]}}, raw[H_W-1:0]};
            default: ext = raw;
        endcase
    end
endmodule

// File: rtl/ldst_disp_unit.sv
module ldst_disp_unit
    import ldst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [3:0]          op_sel,
    input  logic [DISP_W-1:0]   op_disp,
    input  logic [ADDR_W-1:0]   op_base,
    input  logic                fp_wide,
    input  logic [2*DATA_W-1:0] st_data,
    output logic                busy,
    output logic                exc,
    output logic                mem_req,
    input  logic                mem_ready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic [1:0]          mem_size,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_rvalid,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                done,
    output logic [2*DATA_W-1:0] result
);
    localparam int WIDE_W     = 2 * DATA_W;
    localparam int BEAT_BYTES = DATA_W / 8;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RESP} state_e;

    state_e              state_q;
    dec_t                dec_in, op_q;
    logic [ADDR_W-1:0]   addr_in, addr_q;
    logic [WIDE_W-1:0]   wdata_q, res_q;
    logic                beat_q, done_q, exc_q;
    logic [DATA_W-1:0]   ext_data;
    logic                last_beat;

    ldst_decode u_dec (
        .sel  (op_sel),
        .wide (fp_wide),
        .dec  (dec_in)
    );

    ldst_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
        .base  (op_base),
        .disp  (op_disp),
        .shift (dec_in.shift),
        .addr  (addr_in)
    );

    ldst_extend #(.DATA_W(DATA_W)) u_ext (
        .size (op_q.size),
        .zext (op_q.zext),
        .raw  (mem_rdata),
        .ext  (ext_data)
    );

    assign last_beat = !op_q.two_beat || beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            res_q   <= '0;
            beat_q  <= 1'b0;
            done_q  <= 1'b0;
            exc_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            exc_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (op_valid) begin
                        if (dec_in.legal) begin
                            op_q    <= dec_in;
                            addr_q  <= addr_in;
                            wdata_q <= st_data;
                            res_q   <= '0;
                            beat_q  <= 1'b0;
                            state_q <= ST_REQ;
                        end else begin
                            exc_q <= 1'b1;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_ready) state_q <= ST_RESP;
                end
                ST_RESP: begin
                    if (mem_rvalid) begin
                        if (!op_q.store) begin
                            if (!op_q.two_beat)
                                res_q <= {{DATA_W{1'b0}}, ext_data};
                            else if (!beat_q)
                                res_q[WIDE_W-1:DATA_W] <= mem_rdata;
                            else
                                res_q[DATA_W-1:0] <= mem_rdata;
                        end
                        if (last_beat) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            beat_q  <= 1'b1;
                            state_q <= ST_REQ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_req   = (state_q == ST_REQ);
        mem_addr  = beat_q ? addr_q + ADDR_W'(BEAT_BYTES) : addr_q;
        mem_we    = op_q.store;
        mem_size  = op_q.size;
        mem_wdata = (op_q.two_beat && !beat_q) ? wdata_q[WIDE_W-1:DATA_W]
                                               : wdata_q[DATA_W-1:0];
        done      = done_q;
        exc       = exc_q;
        result    = res_q;
    end

    // R10: request and its attributes hold until accepted
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_size)));

    // R8: an undefined selector never starts memory traffic
    p_exc_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        exc |-> (!busy && !mem_req && !done));

    // R9: completion leaves the unit idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: busy only starts from an offered operation
    p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(op_valid));

    // R4: first response of a wide move leads straight to a second request
    p_second_beat_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESP && mem_rvalid && op_q.two_beat && !beat_q)
            |=> (mem_req && !done));

endmodule

// File: tb/ldst_disp_unit_test.sv
module ldst_disp_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [11:0] op_disp = '0;
    logic [31:0] op_base = '0;
    logic        fp_wide = 1'b0;
    logic [63:0] st_data = '0;
    logic        busy, exc, mem_req, mem_we, done;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  mem_size;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ldst_disp_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .op_disp(op_disp), .op_base(op_base), .fp_wide(fp_wide),
        .st_data(st_data), .busy(busy), .exc(exc), .mem_req(mem_req),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .result(result)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5AC3C3;
    endfunction

    function automatic bit is_wide(input logic [3:0] s, input logic w);
        return (s == 4'h3 || s == 4'h7) && w;
    endfunction

    function automatic int scale_of(input logic [3:0] s, input logic w);
        case (s)
            4'h0, 4'h4, 4'h8: return 1;
            4'h1, 4'h5, 4'h9: return 2;
            4'h3, 4'h7:       return w ? 8 : 4;
            default:          return 4;
        endcase
    endfunction

    function automatic logic [1:0] size_of(input logic [3:0] s);
        case (s)
            4'h0, 4'h4, 4'h8: return 2'd0;
            4'h1, 4'h5, 4'h9: return 2'd1;
            default:          return 2'd2;
        endcase
    endfunction

    function automatic logic [31:0] fmt_load(input logic [3:0] s, input logic [31:0] w);
        case (s)
            4'h4: return {{24{w[7]}}, w[7:0]};
            4'h5: return {{16{w[15]}}, w[15:0]};
            4'h8: return {24'h0, w[7:0]};
            4'h9: return {16'h0, w[15:0]};
            default: return w;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory stub: random ready and response delays, logs each beat
    int          stage = 0;
    int          dly = 0;
    int          nb = 0;
    logic [31:0] cur_addr;
    logic [31:0] lg_addr [2];
    logic [31:0] lg_wd   [2];
    logic        lg_we   [2];
    logic [1:0]  lg_sz   [2];

    always @(negedge clk) begin
        mem_ready  = 1'b0;
        mem_rvalid = 1'b0;
        if (!rst) begin
            if (stage == 0) begin
                if (mem_req && ($urandom % 3 != 0)) begin
                    mem_ready = 1'b1;
                    cur_addr  = mem_addr;
                    if (nb < 2) begin
                        lg_addr[nb] = mem_addr;
                        lg_wd[nb]   = mem_wdata;
                        lg_we[nb]   = mem_we;
                        lg_sz[nb]   = mem_size;
                    end
                    nb++;
                    stage = 1;
                    dly   = $urandom % 3;
                end
            end else if (dly == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_word(cur_addr);
                stage      = 0;
            end else begin
                dly--;
            end
        end
    end

    logic [3:0]  e_sel;
    logic [11:0] e_disp;
    logic [31:0] e_base;
    logic        e_wide;
    logic [63:0] e_sd;

    // call at a falling edge
    task automatic launch(input logic [3:0] s, input logic [11:0] d,
                          input logic [31:0] b, input logic w, input logic [63:0] sd);
        e_sel = s; e_disp = d; e_base = b; e_wide = w; e_sd = sd;
        nb = 0;
        op_sel = s; op_disp = d; op_base = b; fp_wide = w; st_data = sd;
        op_valid = 1'b1;
    endtask

    task automatic finish(input bit noise);
        bit          legal, got, two;
        logic [31:0] a0;
        logic [63:0] exp_res;
        string       rq;
        legal = (e_sel <= 4'h9);
        got   = 1'b0;
        @(negedge clk);
        op_valid = 1'b0;
        if (legal) chk(busy === 1'b1, "R9 busy after accept", {63'h0, busy}, 64'h1);
        for (int c = 0; c < 400; c++) begin
            if (done || exc) begin got = 1'b1; break; end
            if (noise) begin op_valid = 1'b1; op_sel = 4'hF; end
            @(negedge clk);
        end
        op_valid = 1'b0;
        if (!got) begin
            chk(1'b0, "R9 operation timed out", 64'h0, 64'h1);
            return;
        end
        if (!legal) begin
            chk(exc === 1'b1 && done === 1'b0, "R8 exc pulse", {62'h0, exc, done}, 64'h2);
            chk(nb == 0, "R8 no memory beat", 64'(nb), 64'h0);
            @(negedge clk);
            chk(exc === 1'b0 && busy === 1'b0, "R8 single pulse, idle",
                {62'h0, exc, busy}, 64'h0);
            return;
        end
        chk(done === 1'b1 && exc === 1'b0, "R9 done without exc", {62'h0, done, exc}, 64'h2);
        chk(busy === 1'b0, "R9 idle at done", {63'h0, busy}, 64'h0);
        two = is_wide(e_sel, e_wide);
        a0  = e_base + 32'(e_disp) * 32'(scale_of(e_sel, e_wide));
        rq  = (e_sel == 4'h3 || e_sel == 4'h7) ? "R3 address" :
              (e_disp[11] ? "R11 address" : "R2 address");
        chk(nb == (two ? 2 : 1), "R4 beat count", 64'(nb), two ? 64'h2 : 64'h1);
        chk(lg_addr[0] == a0, rq, {32'h0, lg_addr[0]}, {32'h0, a0});
        chk(lg_we[0] == (e_sel <= 4'h3), "R1 direction", {63'h0, lg_we[0]},
            {63'h0, (e_sel <= 4'h3)});
        chk(lg_sz[0] == size_of(e_sel), "R7 size code", {62'h0, lg_sz[0]},
            {62'h0, size_of(e_sel)});
        if (two && nb == 2) begin
            chk(lg_addr[1] == a0 + 32'd4, "R4 second beat address",
                {32'h0, lg_addr[1]}, {32'h0, a0 + 32'd4});
            chk(lg_sz[1] == 2'd2, "R7 second beat size", {62'h0, lg_sz[1]}, 64'h2);
        end
        if (e_sel <= 4'h3) begin
            if (two && nb == 2) begin
                chk(lg_wd[0] == e_sd[63:32], "R4 high word first",
                    {32'h0, lg_wd[0]}, {32'h0, e_sd[63:32]});
                chk(lg_wd[1] == e_sd[31:0], "R4 low word second",
                    {32'h0, lg_wd[1]}, {32'h0, e_sd[31:0]});
            end else begin
                chk(lg_wd[0] == e_sd[31:0], "R1 store data",
                    {32'h0, lg_wd[0]}, {32'h0, e_sd[31:0]});
            end
        end else begin
            if (two) begin
                exp_res = {mem_word(a0), mem_word(a0 + 32'd4)};
                rq = "R4 wide load";
            end else begin
                exp_res = {32'h0, fmt_load(e_sel, mem_word(a0))};
                rq = (e_sel == 4'h4 || e_sel == 4'h5) ? "R5 sign extend" :
                     (e_sel == 4'h8 || e_sel == 4'h9) ? "R6 zero extend" : "R7 word load";
            end
            chk(result === exp_res, rq, result, exp_res);
        end
    endtask

    task automatic run_op(input logic [3:0] s, input logic [11:0] d,
                          input logic [31:0] b, input logic w, input logic [63:0] sd,
                          input bit noise);
        @(negedge clk);
        launch(s, d, b, w, sd);
        finish(noise);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && mem_req === 1'b0 && done === 1'b0 && exc === 1'b0,
            "R9 reset state", {60'h0, busy, mem_req, done, exc}, 64'h0);

        // directed: each selector, displacement corner values
        run_op(4'h4, 12'hFFF, 32'h0000_1000, 1'b0, 64'h0, 1'b0);   // R11 R5
        run_op(4'h9, 12'hFFF, 32'hFFFF_F000, 1'b0, 64'h0, 1'b0);   // R11 wrap R6
        run_op(4'h2, 12'h800, 32'h8000_0000, 1'b0, 64'h1122_3344_5566_7788, 1'b0);
        run_op(4'h3, 12'h00A, 32'h0000_0100, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0); // R4
        run_op(4'h7, 12'hFFF, 32'h0001_0000, 1'b1, 64'h0, 1'b0);   // R3 R4
        run_op(4'h7, 12'h123, 32'h0001_0000, 1'b0, 64'h0, 1'b0);   // R3 narrow
        run_op(4'hA, 12'h001, 32'h0, 1'b0, 64'h0, 1'b0);           // R8
        run_op(4'hF, 12'h001, 32'h0, 1'b1, 64'h0, 1'b0);           // R8

        // R9: undefined selector offered throughout a busy period is ignored
        run_op(4'h5, 12'h0F0, 32'h0000_4000, 1'b0, 64'h0, 1'b1);
        run_op(4'h7, 12'h010, 32'h0000_2000, 1'b1, 64'h0, 1'b1);

        // R9: next operation offered in the done cycle
        for (int k = 0; k < 6; k++) begin
            logic [3:0] s2;
            run_op(4'h1, 12'(k * 37), 32'h0000_3000, 1'b0, 64'h0, 1'b1);
            s2 = 4'($urandom % 10);
            launch(s2, 12'($urandom), $urandom, 1'($urandom), {$urandom, $urandom});
            finish(1'b0);
        end

        // constrained random, including undefined selectors
        for (int k = 0; k < 200; k++) begin
            logic [3:0] s;
            s = 4'($urandom % 12);
            if (s >= 4'hA) s = 4'hA + 4'($urandom % 6);
            run_op(s, 12'($urandom), $urandom, 1'($urandom), {$urandom, $urandom},
                   ($urandom % 4) == 0);
        end

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule